// File: doc/BRIEF.md
# MSI-X Interrupt Vector Unit

This block is the device-side part of a message-signalled interrupt scheme with a per-vector table. Each vector has a 16-byte table entry: a 64-bit message address, a 32-bit message data word and a control word whose bit 0 masks the vector. Software reads and writes the entries through a byte-addressed register port. It uses aligned 32-bit or aligned 64-bit transfers. The same port exposes a read-only bit array in which each bit shows that its vector has an undelivered event.

The device logic raises per-vector request pulses. A request on an unmasked vector becomes a memory-write message: the entry's address and data, offered on a valid/ready output. A request on a masked vector, or any request that arrives while the function-wide mask is set, is held as a pending bit. When the mask that blocked it is lifted, the message is sent. Several held vectors drain one after another, lowest index first. The global enable and function mask arrive as plain inputs from the message control register.

The table and pending-array base offsets are given as capability-style 32-bit values. Bits 31:3 are used unshifted as the byte offset, and bits 2:0 are taken as zero.

Top module: `msix_intr_unit`

## Requirements
- R1: Entry v occupies 16 bytes at table base + 16·v. Message address low word is at +0x0, high word at +0x4, message data at +0x8, and the control word at +0xC. Only control bit 0 (1 = vector masked) is stored; the other control bits read as 0.
- R2: After reset every vector's mask bit is 1, every pending bit is 0, every address and data field is 0, and no message is offered.
- R3: Aligned DWORD accesses and aligned QWORD accesses (byte address a multiple of 8) are both supported for reads and writes. A QWORD at entry +0x0 carries address low (bits 31:0) and high (bits 63:32). A QWORD at entry +0x8 carries data (bits 31:0) and control (bits 63:32). Misaligned accesses write nothing and read 0.
- R4: The table base byte address is TBL_OFS with bits 2:0 cleared, and the pending-array base is PBA_OFS with bits 2:0 cleared, with no shift. Addresses outside both regions read 0 and writes to them are dropped.
- R5: In the pending array, bit v of DWORD k shows the pending state of vector 32·k+v. The array is read-only: writes to it change nothing.
- R6: With the unit enabled, a request on a vector whose mask bit is 1 produces no message and sets that vector's pending bit.
- R7: Clearing the mask bit of a vector whose pending bit is set causes its message to be sent. The pending bit clears at the transfer handshake.
- R8: While the function mask is 1, no new message starts and every request becomes pending. Clearing it releases all pending unmasked vectors one after another, back to back when ready stays high.
- R9: While the enable input is 0, request pulses are ignored, no new message starts, and pending bits keep their values.
- R10: When several vectors are eligible at once, the lowest index is sent first.
- R11: An offered message holds valid, address and data stable until ready is high. The vector's pending bit stays set until that handshake.
- R12: A request on an unmasked vector shows as pending after the next clock edge, and its message becomes valid one edge later when the output is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_enable | input | 1 | Global interrupt enable from message control |
| ctl_func_mask | input | 1 | Function-wide mask from message control |
| irq_req | input | NUM_VEC | Per-vector request pulses, one cycle each |
| reg_wr | input | 1 | Register write strobe |
| reg_qword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | REG_AW | Byte address of the access |
| reg_wdata | input | 64 | Write data (DWORD uses bits 31:0) |
| reg_rdata | output | 64 | Read data for reg_addr, combinational (DWORD in bits 31:0) |
| msg_valid | output | 1 | A message write is offered |
| msg_ready | input | 1 | Downstream accepts the offered message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench checks that a request on a masked vector leaves the message output idle and shows up in the pending array. A design that sent it anyway, or lost it, fails there. It writes all ones over the pending array and misaligned QWORDs over the table to catch a read-only or alignment decode that lets writes land. It also checks for a control word decoded at the wrong offset. After the function mask is cleared with four vectors held, the bench collects the drained messages in order. This exposes a design that releases only one message, repeats a vector, or picks a priority other than lowest index first. It also checks that a disabled unit neither accepts requests nor replays held ones, and that a stalled message keeps its pending bit until the handshake.

// File: rtl/msix_pkg.sv
package msix_pkg;

  localparam int unsigned ENTRY_BYTES = 16;

  // Word slots inside one 16-byte table entry; order is decoded by software.
  typedef enum logic [1:0] {
    SLOT_ADDR_LO = 2'd0,
    SLOT_ADDR_HI = 2'd1,
    SLOT_DATA    = 2'd2,
    SLOT_CTRL    = 2'd3
  } slot_e;

  // Offset values keep bits 31:3 in place; the low three bits are not address.
  function automatic logic [31:0] region_base(input logic [31:0] ofs);
    return {ofs[31:3], 3'b000};
  endfunction

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned REG_AW  = 16,
  parameter logic [31:0] TBL_OFS = 32'h0000_0105,
  parameter logic [31:0] PBA_OFS = 32'h0000_0804
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic                      reg_qword,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [63:0]               reg_wdata,
  input  logic [NUM_VEC-1:0]        pba_bits,
  output logic [63:0]               reg_rdata,
  output logic [NUM_VEC-1:0]        vec_mask,
  output logic [NUM_VEC-1:0][63:0]  vec_addr,
  output logic [NUM_VEC-1:0][31:0]  vec_data
);

  localparam int unsigned VIDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int unsigned PBA_QW   = (NUM_VEC + 63) / 64;
  localparam int unsigned PBA_DW   = 2 * PBA_QW;
  localparam int unsigned PW_W     = (PBA_DW > 1) ? $clog2(PBA_DW) : 1;
  localparam logic [31:0] TBL_BASE = region_base(TBL_OFS);
  localparam logic [31:0] TBL_END  = TBL_BASE + 32'(ENTRY_BYTES * NUM_VEC);
  localparam logic [31:0] PBA_BASE = region_base(PBA_OFS);
  localparam logic [31:0] PBA_END  = PBA_BASE + 32'(8 * PBA_QW);

  logic [31:0]       addr32, tbl_off, pba_off;
  logic              aligned, tbl_hit, pba_hit;
  logic [VIDX_W-1:0] vidx;
  logic [1:0]        wsel;
  logic [PW_W-1:0]   pw;

  always_comb begin
    addr32  = 32'(reg_addr);
    aligned = (addr32[1:0] == 2'b00) && !(reg_qword && addr32[2]);
    tbl_hit = aligned && (addr32 >= TBL_BASE) && (addr32 < TBL_END);
    pba_hit = aligned && (addr32 >= PBA_BASE) && (addr32 < PBA_END);
    tbl_off = addr32 - TBL_BASE;
    pba_off = addr32 - PBA_BASE;
    vidx    = tbl_off[4 +: VIDX_W];
    wsel    = tbl_off[3:2];
    pw      = pba_off[2 +: PW_W];
  end

  logic [31:0] words [NUM_VEC][4];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_entry
    logic        sel;
    logic        lo_en, hi_en, dat_en, ctl_en;
    logic [31:0] hi_d;
    logic        ctl_d;
    logic [31:0] lo_q, hi_q, dat_q;
    logic        msk_q;

    // next-state / enable decode
    always_comb begin
      sel    = reg_wr && tbl_hit && (vidx == VIDX_W'(v));
      lo_en  = sel && (wsel == SLOT_ADDR_LO);
      hi_en  = sel && ((wsel == SLOT_ADDR_HI) || (reg_qword && wsel == SLOT_ADDR_LO));
      dat_en = sel && (wsel == SLOT_DATA);
      ctl_en = sel && ((wsel == SLOT_CTRL) || (reg_qword && wsel == SLOT_DATA));
      hi_d   = reg_qword ? reg_wdata[63:32] : reg_wdata[31:0];
      ctl_d  = reg_qword ? reg_wdata[32] : reg_wdata[0];
    end

    // registers
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        dat_q <= '0;
        msk_q <= 1'b1;
      end else begin
        if (lo_en)  lo_q  <= reg_wdata[31:0];
        if (hi_en)  hi_q  <= hi_d;
        if (dat_en) dat_q <= reg_wdata[31:0];
        if (ctl_en) msk_q <= ctl_d;
      end
    end

    assign words[v][0] = lo_q;
    assign words[v][1] = hi_q;
    assign words[v][2] = dat_q;
    assign words[v][3] = {31'b0, msk_q};
    assign vec_mask[v] = msk_q;
    assign vec_addr[v] = {hi_q, lo_q};
    assign vec_data[v] = dat_q;
  end

  logic [PBA_QW*64-1:0] pba_pad;
  logic [31:0]          pba_w [PBA_DW];

  always_comb begin
    pba_pad                = '0;
    pba_pad[NUM_VEC-1:0]   = pba_bits;
  end

  for (genvar k = 0; k < PBA_DW; k++) begin : g_pba_word
    assign pba_w[k] = pba_pad[32*k +: 32];
  end

  always_comb begin
    reg_rdata = '0;
    if (tbl_hit) begin
      reg_rdata[31:0] = words[vidx][wsel];
      if (reg_qword) reg_rdata[63:32] = words[vidx][wsel | 2'b01];
    end else if (pba_hit) begin
      reg_rdata[31:0] = pba_w[pw];
      if (reg_qword) reg_rdata[63:32] = pba_w[pw | PW_W'(1)];
    end
  end

  // R3/R5: a write that misses the table (pending array, misaligned, unmapped)
  // leaves every entry untouched.
  p_stray_write_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !tbl_hit) |=> ($stable(vec_mask) && $stable(vec_addr) && $stable(vec_data)));

endmodule

// File: rtl/msix_pend_track.sv
module msix_pend_track #(
  parameter int unsigned NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_enable,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic [NUM_VEC-1:0] sent_vec,
  output logic [NUM_VEC-1:0] pend
);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_bit
    logic take, pend_d, pend_q;

    always_comb begin
      take   = ctl_enable && irq_req[v];
      pend_d = pend_q;
      if (sent_vec[v]) pend_d = 1'b0;
      if (take)        pend_d = 1'b1;   // a fresh event outranks a completing send
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
    end

    assign pend[v] = pend_q;

    // R6/R8: an accepted request is never lost.
    p_req_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_enable && irq_req[v]) |=> pend[v]);

    // R9: while disabled, only a completing handshake may change the bit.
    p_disabled_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_enable && !sent_vec[v]) |=> $stable(pend[v]));
  end

endmodule

// File: rtl/msix_msg_arb.sv
module msix_msg_arb #(
  parameter int unsigned NUM_VEC = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctl_enable,
  input  logic                      func_mask,
  input  logic [NUM_VEC-1:0]        pend,
  input  logic [NUM_VEC-1:0]        vec_mask,
  input  logic [NUM_VEC-1:0][63:0]  vec_addr,
  input  logic [NUM_VEC-1:0][31:0]  vec_data,
  input  logic                      msg_ready,
  output logic                      msg_valid,
  output logic [63:0]               msg_addr,
  output logic [31:0]               msg_data,
  output logic [NUM_VEC-1:0]        sent_vec
);

  localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic               valid_q, valid_d;
  logic [63:0]        addr_q, addr_d;
  logic [31:0]        data_q, data_d;
  logic [NUM_VEC-1:0] cur_q, cur_d;

  logic [NUM_VEC-1:0] busy, eligible, pick_oh;
  logic [IDX_W-1:0]   pick_idx;
  logic               found, can_load, launch, handshake;

  always_comb begin
    handshake = valid_q && msg_ready;
    busy      = valid_q ? cur_q : '0;
    eligible  = pend & ~vec_mask & ~busy & {NUM_VEC{ctl_enable && !func_mask}};
    pick_idx  = '0;
    found     = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (eligible[i] && !found) begin
        pick_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
    pick_oh  = NUM_VEC'(1) << pick_idx;
    can_load = !valid_q || msg_ready;
    launch   = can_load && found;
  end

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    data_d  = data_q;
    cur_d   = cur_q;
    if (handshake) valid_d = 1'b0;
    if (launch) begin
      valid_d = 1'b1;
      addr_d  = vec_addr[pick_idx];
      data_d  = vec_data[pick_idx];
      cur_d   = pick_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      cur_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (launch) begin
        addr_q <= addr_d;
        data_q <= data_d;
        cur_q  <= cur_d;
      end
    end
  end

  assign msg_valid = valid_q;
  assign msg_addr  = addr_q;
  assign msg_data  = data_q;
  assign sent_vec  = handshake ? cur_q : '0;

  // R11: an offered message is held unchanged until accepted.
  p_hold_until_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R11: at most one vector completes per cycle.
  p_single_send_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sent_vec));

  // R7: the vector completing a handshake is still marked pending.
  p_sent_was_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |-> ((sent_vec & pend) != '0));

  // R8/R9: a newly loaded message only starts while enabled and unmasked at function level.
  p_start_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (!$past(msg_valid) || $past(msg_ready))) |-> $past(ctl_enable && !func_mask));

endmodule

// File: rtl/msix_intr_unit.sv
module msix_intr_unit
  import msix_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned REG_AW  = 16,
  parameter logic [31:0] TBL_OFS = 32'h0000_0105,
  parameter logic [31:0] PBA_OFS = 32'h0000_0804
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_enable,
  input  logic               ctl_func_mask,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               reg_wr,
  input  logic               reg_qword,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);

  // Reset asserts at once, deasserts two edges after the input rises.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_VEC-1:0]       pend, vec_mask, sent_vec;
  logic [NUM_VEC-1:0][63:0] vec_addr;
  logic [NUM_VEC-1:0][31:0] vec_data;

  msix_vec_table #(
    .NUM_VEC (NUM_VEC),
    .REG_AW  (REG_AW),
    .TBL_OFS (TBL_OFS),
    .PBA_OFS (PBA_OFS)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_wr    (reg_wr),
    .reg_qword (reg_qword),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pba_bits  (pend),
    .reg_rdata (reg_rdata),
    .vec_mask  (vec_mask),
    .vec_addr  (vec_addr),
    .vec_data  (vec_data)
  );

  msix_pend_track #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ctl_enable (ctl_enable),
    .irq_req    (irq_req),
    .sent_vec   (sent_vec),
    .pend       (pend)
  );

  msix_msg_arb #(.NUM_VEC(NUM_VEC)) u_arb (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ctl_enable (ctl_enable),
    .func_mask  (ctl_func_mask),
    .pend       (pend),
    .vec_mask   (vec_mask),
    .vec_addr   (vec_addr),
    .vec_data   (vec_data),
    .msg_ready  (msg_ready),
    .msg_valid  (msg_valid),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data),
    .sent_vec   (sent_vec)
  );

  // R12: a message never appears while everything was idle the cycle before.
  p_no_spurious_msg_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$past(msg_valid) && ($past(pend) == '0)) |-> !msg_valid);

endmodule

// File: tb/msix_intr_unit_tb_top.sv
`timescale 1ns/100ps
module msix_intr_unit_tb_top;

  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_enable, ctl_func_mask;
  logic [NV-1:0] irq_req;
  logic          reg_wr, reg_qword;
  logic [15:0]   reg_addr;
  logic [63:0]   reg_wdata, reg_rdata;
  logic          msg_valid, msg_ready;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  msix_intr_unit #(.NUM_VEC(NV)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_func_mask(ctl_func_mask),
    .irq_req(irq_req), .reg_wr(reg_wr), .reg_qword(reg_qword), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  typedef struct packed {
    logic        wr;
    logic        qw;
    logic [15:0] addr;
    logic [63:0] data;
    logic [63:0] exp;
  } rv_t;

  // Table base 0x100, pending array base 0x800 (offsets 0x105 / 0x804, low bits dropped).
  localparam int NRV = 26;
  localparam rv_t RV [NRV] = '{
    '{1'b0, 1'b0, 16'h017C, 64'h0, 64'h0000_0000_0000_0001},   // R2 mask reset
    '{1'b0, 1'b1, 16'h0178, 64'h0, 64'h0000_0001_0000_0000},   // R2 data + ctrl
    '{1'b0, 1'b1, 16'h0170, 64'h0, 64'h0},                     // R2 address
    '{1'b0, 1'b1, 16'h0800, 64'h0, 64'h0},                     // R2 pending
    '{1'b1, 1'b0, 16'h0100, 64'h0000_0000_CAFE_0010, 64'h0},
    '{1'b1, 1'b0, 16'h0104, 64'h0000_0000_0000_00AB, 64'h0},
    '{1'b0, 1'b1, 16'h0100, 64'h0, 64'h0000_00AB_CAFE_0010},   // R3 qword read
    '{1'b1, 1'b1, 16'h0118, 64'hFFFF_FFFE_1234_5678, 64'h0},
    '{1'b0, 1'b0, 16'h011C, 64'h0, 64'h0},                     // R1 ctrl at +0xC
    '{1'b0, 1'b0, 16'h0118, 64'h0, 64'h0000_0000_1234_5678},   // R1 data at +0x8
    '{1'b1, 1'b0, 16'h011C, 64'h0000_0000_FFFF_FFFF, 64'h0},
    '{1'b0, 1'b1, 16'h0118, 64'h0, 64'h0000_0001_1234_5678},   // R1 only bit 0 kept
    '{1'b1, 1'b1, 16'h0120, 64'h1111_2222_3333_4444, 64'h0},
    '{1'b0, 1'b0, 16'h0124, 64'h0, 64'h0000_0000_1111_2222},   // R3 qword write hi
    '{1'b1, 1'b1, 16'h0124, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},   // misaligned qword
    '{1'b0, 1'b0, 16'h0124, 64'h0, 64'h0000_0000_1111_2222},   // R3 ignored
    '{1'b0, 1'b0, 16'h0102, 64'h0, 64'h0},                     // R3 misaligned read
    '{1'b0, 1'b1, 16'h0124, 64'h0, 64'h0},                     // R3 misaligned qword read
    '{1'b1, 1'b0, 16'h0800, 64'h0000_0000_FFFF_FFFF, 64'h0},
    '{1'b0, 1'b0, 16'h0800, 64'h0, 64'h0},                     // R5 read-only
    '{1'b0, 1'b0, 16'h00FC, 64'h0, 64'h0},                     // R4 below table
    '{1'b0, 1'b0, 16'h0180, 64'h0, 64'h0},                     // R4 past table
    '{1'b0, 1'b0, 16'h0020, 64'h0, 64'h0},                     // R4 no shift
    '{1'b1, 1'b0, 16'h0108, 64'h0000_0000_0000_5555, 64'h0},
    '{1'b0, 1'b0, 16'h0108, 64'h0, 64'h0000_0000_0000_5555},   // R1 data dword
    '{1'b0, 1'b0, 16'h0104, 64'h0, 64'h0000_0000_0000_00AB}    // R1 addr hi
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic qw, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_qword = qw; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [15:0] a, input logic qw, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_qword = qw;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_irq(input logic [NV-1:0] m);
    @(negedge clk);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  function automatic logic [31:0] ent_data(input int i);
    return 32'hD000_0000 + 32'(i);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] rd;
    logic [31:0] seen [8];
    int          nseen;

    rst_n = 1'b0; ctl_enable = 1'b1; ctl_func_mask = 1'b0; irq_req = '0;
    reg_wr = 1'b0; reg_qword = 1'b0; reg_addr = '0; reg_wdata = '0; msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 msg_valid after reset", 64'(msg_valid), 64'h0);

    // Register vectors: R1, R2, R3, R4, R5
    for (int i = 0; i < NRV; i++) begin
      if (RV[i].wr) reg_write(RV[i].addr, RV[i].qw, RV[i].data);
      else begin
        reg_read(RV[i].addr, RV[i].qw, rd);
        chk($sformatf("R1/R3/R4/R5 register vector %0d", i), rd, RV[i].exp);
      end
    end

    // Program every entry's address and data (controls stay masked).
    for (int i = 0; i < NV; i++) begin
      reg_write(16'h0100 + 16'(16 * i), 1'b1, {32'hFEE0_0000, 32'h0000_1000 + 32'(16 * i)});
      reg_write(16'h0108 + 16'(16 * i), 1'b0, 64'(ent_data(i)));
    end

    // R6: masked request only pends.
    pulse_irq(8'h04);
    repeat (3) @(negedge clk);
    chk("R6 no message while masked", 64'(msg_valid), 64'h0);
    reg_read(16'h0800, 1'b0, rd);
    chk("R6 pending bit set", rd, 64'h04);

    // R5: writing the pending array changes nothing.
    reg_write(16'h0800, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_read(16'h0800, 1'b1, rd);
    chk("R5 pending array write ignored", rd, 64'h04);

    // R7: unmasking replays the held vector.
    reg_write(16'h012C, 1'b0, 64'h0);
    chk("R7 not yet launched", 64'(msg_valid), 64'h0);
    @(negedge clk);
    chk("R7 replay valid", 64'(msg_valid), 64'h1);
    chk("R7 replay address", msg_addr, 64'hFEE0_0000_0000_1020);
    chk("R7 replay data", 64'(msg_data), 64'(ent_data(2)));
    repeat (2) @(negedge clk);
    reg_read(16'h0800, 1'b0, rd);
    chk("R11 pending held while stalled", rd, 64'h04);
    chk("R11 valid held while stalled", 64'(msg_valid), 64'h1);
    chk("R11 data held while stalled", 64'(msg_data), 64'(ent_data(2)));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk("R7 valid drops after handshake", 64'(msg_valid), 64'h0);
    reg_read(16'h0800, 1'b0, rd);
    chk("R7 pending cleared after send", rd, 64'h0);

    // R8/R10: function mask holds everything, release drains lowest first.
    ctl_func_mask = 1'b1;
    reg_write(16'h011C, 1'b0, 64'h0);
    reg_write(16'h013C, 1'b0, 64'h0);
    reg_write(16'h015C, 1'b0, 64'h0);
    pulse_irq(8'h2E);
    repeat (2) @(negedge clk);
    chk("R8 no message under function mask", 64'(msg_valid), 64'h0);
    reg_read(16'h0800, 1'b0, rd);
    chk("R8 all requests pending", rd, 64'h2E);
    @(negedge clk);
    ctl_func_mask = 1'b0;
    msg_ready = 1'b1;
    nseen = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (msg_valid && nseen < 8) begin
        seen[nseen] = msg_data;
        nseen++;
      end
    end
    msg_ready = 1'b0;
    chk("R8 drained message count", 64'(nseen), 64'h4);
    chk("R10 first vector 1", 64'(seen[0]), 64'(ent_data(1)));
    chk("R10 second vector 2", 64'(seen[1]), 64'(ent_data(2)));
    chk("R10 third vector 3", 64'(seen[2]), 64'(ent_data(3)));
    chk("R10 fourth vector 5", 64'(seen[3]), 64'(ent_data(5)));
    reg_read(16'h0800, 1'b0, rd);
    chk("R8 pending empty after drain", rd, 64'h0);

    // R9: disabled unit ignores requests and holds its pending bits.
    ctl_enable = 1'b0;
    pulse_irq(8'h02);
    repeat (2) @(negedge clk);
    chk("R9 no message while disabled", 64'(msg_valid), 64'h0);
    reg_read(16'h0800, 1'b0, rd);
    chk("R9 request ignored while disabled", rd, 64'h0);
    ctl_enable = 1'b1;
    pulse_irq(8'h10);
    ctl_enable = 1'b0;
    reg_write(16'h014C, 1'b0, 64'h0);
    repeat (3) @(negedge clk);
    chk("R9 no replay while disabled", 64'(msg_valid), 64'h0);
    reg_read(16'h0800, 1'b0, rd);
    chk("R9 pending kept while disabled", rd, 64'h10);
    @(negedge clk);
    ctl_enable = 1'b1;
    @(negedge clk);
    chk("R9 replay after enable", 64'(msg_valid), 64'h1);
    chk("R9 replay data", 64'(msg_data), 64'(ent_data(4)));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;

    // R12: latency of a request on an unmasked vector.
    @(negedge clk);
    irq_req = 8'h08;
    @(negedge clk);
    irq_req = '0;
    chk("R12 not valid one edge after request", 64'(msg_valid), 64'h0);
    #1 reg_addr = 16'h0800; reg_qword = 1'b0;
    #1 chk("R12 pending visible", reg_rdata, 64'h08);
    @(negedge clk);
    chk("R12 valid two edges after request", 64'(msg_valid), 64'h1);
    chk("R12 data", 64'(msg_data), 64'(ent_data(3)));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk("R12 idle after send", 64'(msg_valid), 64'h0);

    finish_run();
  end

endmodule